// File: doc/BRIEF.md
# Message Link Beat Serializer and Reassembler

This block moves fixed 14-byte messages from a translation client to a central translation unit across a point-to-point link. The link's data width is set when the block is built. A transmit half takes a whole message from a source, cuts it into beats that fit the link, and sends them one at a time. A receive half collects the beats and hands the rebuilt message to a sink in a single transfer.

The source, the sink and every link beat use valid/ready handshakes. Back-pressure at either end of the link, or on the link itself, holds data in place and never drops or repeats it.

A compile-time mode picks the link width. The full-width mode sends the message in one beat. The half-width mode sends it in two beats. The byte-wide mode sends it in fourteen beats, which saves wiring on links to lower-priority clients at the cost of latency. Both halves sit in one top module, and the link pins are brought out so that the two halves can be joined directly or through other link logic.

Top module: `msg_link_serdes`

## Requirements
- R1: `LINK_MODE` sets the beat width and the number of beats per message. Mode 0 sends one 112-bit beat, mode 1 sends two 56-bit beats, and mode 2 sends fourteen 8-bit beats.
- R2: Beat k carries message bits [k*W+W-1 : k*W], where W is the beat width. Byte 0 is bits [7:0], so the lowest-addressed bytes go first.
- R3: `txl_last` is high on the final beat of each message and low on every other beat. The receiver takes `rxl_last` as the end of a message.
- R4: `src_ready` is high when the transmitter is idle. An accepted message presents its first beat in the next cycle. `src_ready` then stays low until the final beat completes its handshake.
- R5: While `txl_ready` is low, a pending beat keeps `txl_valid`, `txl_data` and `txl_last` unchanged. Stalls of any length neither lose nor repeat a beat.
- R6: `dst_valid` rises in the cycle after the final beat is accepted and not earlier. `dst_data` then equals the message that was sent.
- R7: While `dst_valid` is high and `dst_ready` is low, `dst_data` holds steady and `rxl_ready` stays low. A transfer with `dst_ready` high clears `dst_valid` in the next cycle.
- R8: A synchronous active-high `rst` clears both beat counters and drops any partly sent or partly assembled message. After reset, `src_ready` and `rxl_ready` are high, and `txl_valid` and `dst_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Source offers a message |
| src_ready | output | 1 | Transmitter can take a message |
| src_data | input | 112 | Message from the source, byte 0 in bits [7:0] |
| txl_valid | output | 1 | Outgoing beat valid |
| txl_ready | input | 1 | Link accepts the outgoing beat |
| txl_data | output | BW (112/56/8) | Outgoing beat payload |
| txl_last | output | 1 | Outgoing beat is the final one of its message |
| rxl_valid | input | 1 | Incoming beat valid |
| rxl_ready | output | 1 | Receiver can take a beat |
| rxl_data | input | BW (112/56/8) | Incoming beat payload |
| rxl_last | input | 1 | Incoming beat is the final one of its message |
| dst_valid | output | 1 | Rebuilt message available |
| dst_ready | input | 1 | Sink accepts the message |
| dst_data | output | 112 | Rebuilt message |

## Verification
The checker assumes that beats arriving on the receive pins are framed the way this block's own transmitter frames them: `rxl_last` is set exactly on every Nth accepted beat for the mode in use. It also assumes that a link holds a beat until it is accepted.

The bench keeps within both assumptions by feeding each receive half only from its own transmit half. A shared pseudo-random gate stalls `rxl_valid` and `txl_ready` together, so a stalled beat is never dropped or reshaped. One instance of each mode is driven from the same message stream, so one run covers all three widths under the same stalls and sink delays.

// File: rtl/msglink_pkg.sv
package msglink_pkg;
    localparam int MSG_BYTES = 14;
    localparam int MSG_W     = MSG_BYTES * 8;

    // bytes carried per beat for each transport mode
    function automatic int beat_bytes(input int mode);
        case (mode)
            0:       return MSG_BYTES;
            1:       return MSG_BYTES / 2;
            default: return 1;
        endcase
    endfunction

    function automatic int beat_count(input int mode);
        return MSG_BYTES / beat_bytes(mode);
    endfunction
endpackage

// File: rtl/msglink_tx.sv
module msglink_tx
    import msglink_pkg::*;
#(
    parameter int LINK_MODE = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     src_valid,
    output logic                     src_ready,
    input  logic [MSG_W-1:0]         src_data,
    output logic                     lnk_valid,
    input  logic                     lnk_ready,
    output logic [beat_bytes(LINK_MODE)*8-1:0] lnk_data,
    output logic                     lnk_last
);
    localparam int BW = beat_bytes(LINK_MODE) * 8;
    localparam int NB = beat_count(LINK_MODE);
    localparam int CW = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(NB - 1);

    typedef struct packed {
        logic             busy;
        logic [CW-1:0]    cnt;
        logic [MSG_W-1:0] hold;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy && src_valid) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.hold = src_data;
        end else if (st_q.busy && lnk_ready) begin
            if (st_q.cnt == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_ready = !st_q.busy;
    assign lnk_valid = st_q.busy;
    assign lnk_data  = st_q.hold[BW*st_q.cnt +: BW];
    assign lnk_last  = (st_q.cnt == LAST_IDX);
endmodule

// File: rtl/msglink_rx.sv
module msglink_rx
    import msglink_pkg::*;
#(
    parameter int LINK_MODE = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     lnk_valid,
    output logic                     lnk_ready,
    input  logic [beat_bytes(LINK_MODE)*8-1:0] lnk_data,
    input  logic                     lnk_last,
    output logic                     dst_valid,
    input  logic                     dst_ready,
    output logic [MSG_W-1:0]         dst_data
);
    localparam int BW = beat_bytes(LINK_MODE) * 8;
    localparam int NB = beat_count(LINK_MODE);
    localparam int CW = (NB > 1) ? $clog2(NB) : 1;

    typedef struct packed {
        logic             full;
        logic [CW-1:0]    cnt;
        logic [MSG_W-1:0] asm_buf;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.full && dst_ready) begin
            st_d.full = 1'b0;
        end
        if (!st_q.full && lnk_valid) begin
            st_d.asm_buf[BW*st_q.cnt +: BW] = lnk_data;
            if (lnk_last) begin
                st_d.full = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lnk_ready = !st_q.full;
    assign dst_valid = st_q.full;
    assign dst_data  = st_q.asm_buf;
endmodule

// File: rtl/msg_link_serdes.sv
module msg_link_serdes
    import msglink_pkg::*;
#(
    parameter int LINK_MODE = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     src_valid,
    output logic                     src_ready,
    input  logic [MSG_W-1:0]         src_data,
    output logic                     txl_valid,
    input  logic                     txl_ready,
    output logic [beat_bytes(LINK_MODE)*8-1:0] txl_data,
    output logic                     txl_last,
    input  logic                     rxl_valid,
    output logic                     rxl_ready,
    input  logic [beat_bytes(LINK_MODE)*8-1:0] rxl_data,
    input  logic                     rxl_last,
    output logic                     dst_valid,
    input  logic                     dst_ready,
    output logic [MSG_W-1:0]         dst_data
);
    msglink_tx #(.LINK_MODE(LINK_MODE)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .src_valid (src_valid),
        .src_ready (src_ready),
        .src_data  (src_data),
        .lnk_valid (txl_valid),
        .lnk_ready (txl_ready),
        .lnk_data  (txl_data),
        .lnk_last  (txl_last)
    );

    msglink_rx #(.LINK_MODE(LINK_MODE)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .lnk_valid (rxl_valid),
        .lnk_ready (rxl_ready),
        .lnk_data  (rxl_data),
        .lnk_last  (rxl_last),
        .dst_valid (dst_valid),
        .dst_ready (dst_ready),
        .dst_data  (dst_data)
    );
endmodule

// File: rtl/msg_link_serdes_chk.sv
module msg_link_serdes_chk
    import msglink_pkg::*;
#(
    parameter int LINK_MODE = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     src_valid,
    input logic                     src_ready,
    input logic [MSG_W-1:0]         src_data,
    input logic                     txl_valid,
    input logic                     txl_ready,
    input logic [beat_bytes(LINK_MODE)*8-1:0] txl_data,
    input logic                     txl_last,
    input logic                     rxl_valid,
    input logic                     rxl_ready,
    input logic [beat_bytes(LINK_MODE)*8-1:0] rxl_data,
    input logic                     rxl_last,
    input logic                     dst_valid,
    input logic                     dst_ready,
    input logic [MSG_W-1:0]         dst_data
);
    localparam int NB = beat_count(LINK_MODE);

    // independent beat positions, counted from handshakes
    int tx_pos, rx_pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_pos <= 0;
            rx_pos <= 0;
        end else begin
            if (txl_valid && txl_ready) begin
                tx_pos <= (tx_pos == NB - 1) ? 0 : tx_pos + 1;
            end
            if (rxl_valid && rxl_ready) begin
                rx_pos <= (rx_pos == NB - 1) ? 0 : rx_pos + 1;
            end
        end
    end

    assert_last_flag_R3: assert property (@(posedge clk) disable iff (rst)
        txl_valid |-> (txl_last == (tx_pos == NB - 1)));

    // input assumption: incoming beats framed as this block frames them
    assert_rx_framing_R3: assert property (@(posedge clk) disable iff (rst)
        rxl_valid |-> (rxl_last == (rx_pos == NB - 1)));

    assert_first_beat_R4: assert property (@(posedge clk) disable iff (rst)
        (src_valid && src_ready) |=> (txl_valid && !src_ready));

    assert_busy_blocks_src_R4: assert property (@(posedge clk) disable iff (rst)
        txl_valid |-> !src_ready);

    assert_beat_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (txl_valid && !txl_ready) |=>
            (txl_valid && $stable(txl_data) && $stable(txl_last)));

    assert_done_on_last_R6: assert property (@(posedge clk) disable iff (rst)
        (rxl_valid && rxl_ready && rxl_last) |=> dst_valid);

    assert_no_early_done_R6: assert property (@(posedge clk) disable iff (rst)
        (rxl_valid && rxl_ready && !rxl_last) |=> !dst_valid);

    assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_data)));

    assert_full_blocks_link_R7: assert property (@(posedge clk) disable iff (rst)
        dst_valid |-> !rxl_ready);

    assert_reset_state_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!txl_valid && !dst_valid && src_ready && rxl_ready));
endmodule

bind msg_link_serdes msg_link_serdes_chk #(.LINK_MODE(LINK_MODE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .src_data  (src_data),
    .txl_valid (txl_valid),
    .txl_ready (txl_ready),
    .txl_data  (txl_data),
    .txl_last  (txl_last),
    .rxl_valid (rxl_valid),
    .rxl_ready (rxl_ready),
    .rxl_data  (rxl_data),
    .rxl_last  (rxl_last),
    .dst_valid (dst_valid),
    .dst_ready (dst_ready),
    .dst_data  (dst_data)
);

// File: tb/msg_link_serdes_bench.sv
module msg_link_serdes_bench;
    localparam int NV = 6;
    localparam logic [111:0] VEC_MSG [NV] = '{
        112'h0e0d0c0b0a090807060504030201,
        112'h0,
        112'hffff_ffff_ffff_ffff_ffff_ffff_ffff,
        112'ha5a5_a5a5_a5a5_a5a5_a5a5_a5a5_a5a5,
        112'h8000_0000_0000_0000_0000_0000_0001,
        112'hdead_beef_cafe_f00d_1234_5678_9abc
    };
    localparam int VEC_STALL [NV] = '{0, 1, 2, 1, 2, 0};
    localparam int VEC_WAIT  [NV] = '{0, 0, 3, 5, 1, 2};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic src_valid = 1'b0;
    logic [111:0] src_data = '0;
    logic dst_ready = 1'b0;
    logic go = 1'b1;
    int   stall_en = 0;
    logic [7:0] lfsr = 8'h5b;
    logic [111:0] exp_msg = '0;

    int n_chk = 0, n_fail = 0, wd_fail = 0;

    logic [2:0] b_src_ready, b_txl_valid, b_dst_valid, b_rxl_ready;
    logic [111:0] b_dst_data [3];
    int b_beats [3];
    int b_chk [3];
    int b_fail [3];

    always #2 clk = ~clk;

    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (stall_en)
            1:       go <= (lfsr[1:0] != 2'b00);
            2:       go <= lfsr[0];
            default: go <= 1'b1;
        endcase
    end

    for (genvar m = 0; m < 3; m++) begin : g_mode
        localparam int BW = (m == 0) ? 112 : (m == 1) ? 56 : 8;
        localparam int NB = 112 / BW;
        logic sr, tv, tr, tl, rr, dv;
        logic [BW-1:0] td;
        logic [111:0] dd;
        int n_c = 0, n_f = 0, n_b = 0, idx = 0;

        msg_link_serdes #(.LINK_MODE(m)) u_msg_link_serdes (
            .clk       (clk),
            .rst       (rst),
            .src_valid (src_valid),
            .src_ready (sr),
            .src_data  (src_data),
            .txl_valid (tv),
            .txl_ready (tr),
            .txl_data  (td),
            .txl_last  (tl),
            .rxl_valid (tv & go),
            .rxl_ready (rr),
            .rxl_data  (td),
            .rxl_last  (tl),
            .dst_valid (dv),
            .dst_ready (dst_ready),
            .dst_data  (dd)
        );
        assign tr = rr & go;

        // beat monitor: order (R2) and last flag (R3)
        always @(posedge clk) begin
            if (rst) begin
                idx = 0;
            end else if (tv && tr) begin
                n_c = n_c + 1;
                if (td !== exp_msg[idx*BW +: BW]) begin
                    n_f = n_f + 1;
                    $display("FAIL R2 mode%0d beat %0d: got %h expected %h",
                             m, idx, td, exp_msg[idx*BW +: BW]);
                end
                n_c = n_c + 1;
                if (tl !== (idx == NB - 1)) begin
                    n_f = n_f + 1;
                    $display("FAIL R3 mode%0d beat %0d: got %0d expected %0d",
                             m, idx, tl, (idx == NB - 1));
                end
                n_b = n_b + 1;
                idx = (idx == NB - 1) ? 0 : idx + 1;
            end
        end

        assign b_src_ready[m] = sr;
        assign b_txl_valid[m] = tv;
        assign b_dst_valid[m] = dv;
        assign b_rxl_ready[m] = rr;
        assign b_dst_data[m]  = dd;
        assign b_beats[m]     = n_b;
        assign b_chk[m]       = n_c;
        assign b_fail[m]      = n_f;
    end

    function automatic int exp_beats(input int m);
        return (m == 0) ? 1 : (m == 1) ? 2 : 14;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [111:0] act, input logic [111:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        int tot, bad;
        tot = n_chk + wd_fail;
        bad = n_fail + wd_fail;
        for (int m = 0; m < 3; m++) begin
            tot += b_chk[m];
            bad += b_fail[m];
        end
        $display("  %0d/%0d checks passed", tot - bad, tot);
    endtask

    task automatic xfer(input logic [111:0] msg, input int wait_cyc);
        int start [3];
        exp_msg = msg;
        for (int m = 0; m < 3; m++) start[m] = b_beats[m];
        @(negedge clk);
        check(b_src_ready == 3'b111, "R4", "idle src_ready", 112'(b_src_ready), 112'h7);
        src_valid = 1'b1;
        src_data  = msg;
        @(negedge clk);
        src_valid = 1'b0;
        check(b_txl_valid == 3'b111 && b_src_ready == 3'b000, "R4",
              "first beat up, src_ready low", 112'({b_txl_valid, b_src_ready}), 112'h38);
        while (b_dst_valid != 3'b111) @(negedge clk);
        for (int m = 0; m < 3; m++) begin
            check(b_dst_data[m] == msg, "R6", $sformatf("mode%0d message", m),
                  b_dst_data[m], msg);
            check(b_beats[m] - start[m] == exp_beats(m), "R1",
                  $sformatf("mode%0d beat count", m),
                  112'(b_beats[m] - start[m]), 112'(exp_beats(m)));
        end
        if (wait_cyc > 0) begin
            repeat (wait_cyc) @(negedge clk);
            for (int m = 0; m < 3; m++) begin
                check(b_dst_valid[m] && b_dst_data[m] == msg && !b_rxl_ready[m], "R7",
                      $sformatf("mode%0d held output", m), b_dst_data[m], msg);
            end
        end
        dst_ready = 1'b1;
        @(negedge clk);
        dst_ready = 1'b0;
        check(b_dst_valid == 3'b000, "R7", "dst_valid cleared after accept",
              112'(b_dst_valid), 112'h0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        wd_fail = 1;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: state after reset
        check(b_src_ready == 3'b111 && b_rxl_ready == 3'b111, "R8", "readies after reset",
              112'({b_src_ready, b_rxl_ready}), 112'h3f);
        check(b_txl_valid == 3'b000 && b_dst_valid == 3'b000, "R8", "valids after reset",
              112'({b_txl_valid, b_dst_valid}), 112'h0);

        // vector table: messages under stall patterns and sink delays (R1 R2 R5 R6 R7)
        for (int v = 0; v < NV; v++) begin
            stall_en = VEC_STALL[v];
            xfer(VEC_MSG[v], VEC_WAIT[v]);
        end

        // R5: heavy stall, back-to-back messages
        stall_en = 2;
        xfer(112'h1111_2222_3333_4444_5555_6666_7777, 4);
        xfer(112'h0123_4567_89ab_cdef_fedc_ba98_7654, 0);
        stall_en = 0;

        // R8: reset in mid-message drops the partial message
        exp_msg = 112'hbbbb_bbbb_bbbb_bbbb_bbbb_bbbb_bbbb;
        @(negedge clk);
        src_valid = 1'b1;
        src_data  = exp_msg;
        @(negedge clk);
        src_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(b_txl_valid[2] == 1'b1, "R8", "mode2 mid-message before reset",
              112'(b_txl_valid[2]), 112'h1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(b_txl_valid == 3'b000 && b_dst_valid == 3'b000, "R8",
              "valids cleared by mid-message reset",
              112'({b_txl_valid, b_dst_valid}), 112'h0);
        check(b_src_ready == 3'b111 && b_rxl_ready == 3'b111, "R8",
              "readies after mid-message reset",
              112'({b_src_ready, b_rxl_ready}), 112'h3f);
        xfer(112'hc3c3_0000_ffff_1234_0000_5a5a_0001, 0);

        report();
        $finish;
    end
endmodule